// File: doc/BRIEF.md
# Debug Power and Reset Controller

This block holds the power and reset controls for an embedded debug domain. A small register bus reaches two 8-bit registers. The control register drives the reset lines for the core and the debug domain, and it drives the wakeup requests for the core, memory and debug power domains. The status register shows which domains report power-good. It also holds sticky flags that record when the core or the debug domain has gone through reset.

Debug access over the scan path is guarded by an enable bit. The enable becomes effective only on a 0-to-1 write, and only while the debug reset is released. Any write made while the enable is set clears it. Software therefore writes it back to 1 on a later write to regain access. Debug reset also removes the enable.

The external power switches are represented by plain power-good inputs. The register bus has single-cycle writes and a combinational read of the selected register.

Top module: `dbg_pwr_ctl`

## Requirements
- R1: While `rst` is high the control register clears to 0x00 and every output request, reset and access line is low. The status register reads 0x50 with no power-good input high.
- R2: A control write loads the core wakeup (bit 0), memory wakeup (bit 1), debug wakeup (bit 2), core reset (bit 4) and debug reset (bit 6). These bits drive `core_pwr_req`, `mem_pwr_req`, `dbg_pwr_req`, `core_rst_o` and `dbg_rst_o` directly. Bits 3 and 5 read back as 0.
- R3: Control bit 7 (scan debug enable) is set only by a write that carries 1 in bit 7 while the bit is currently 0 and the written bit 6 is 0. `jtag_access_ok` goes high on exactly such a write.
- R4: Any control write made while bit 7 is 1 clears bit 7 and `jtag_access_ok`, whatever data it carries.
- R5: While debug reset (bit 6) is 1, bit 7 and `jtag_access_ok` stay 0, even when a write carries 1 in bit 7.
- R6: Status bits 0, 1 and 2 (core, memory, debug domain on) and bit 3 (core still needed) follow `core_pgood`, `mem_pgood`, `dbg_pgood` and `core_needed` with one cycle of delay.
- R7: Status bit 4 (core was reset) is set in every cycle in which core reset is driven. Status bit 6 (debug was reset) is set in every cycle in which debug reset is driven. Both bits are also set by `rst`.
- R8: A status write of 1 to bit 4 or bit 6 clears that flag, and a 0 leaves it alone. A reset that is still active wins over the clear. Writes to the other status bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| core_pgood | input | 1 | Core domain power-good |
| mem_pgood | input | 1 | Memory domain power-good |
| dbg_pgood | input | 1 | Debug domain power-good |
| core_needed | input | 1 | Core is still required by the system |
| core_pwr_req | output | 1 | Core domain wakeup request |
| mem_pwr_req | output | 1 | Memory domain wakeup request |
| dbg_pwr_req | output | 1 | Debug domain wakeup request |
| core_rst_o | output | 1 | Core reset |
| dbg_rst_o | output | 1 | Debug domain reset |
| jtag_access_ok | output | 1 | Scan-path debug access granted |

## Verification
The hardest case to reach is the interaction between the enable and the reset and write history. The access line must drop on a rewrite of 1, rise again on the write after that, and refuse to arm while debug reset is held. The stimulus walks through that exact write sequence: arm, rewrite, re-arm, reset with bit 7 set, then write bit 7 while reset is held. It then tries to clear the core-was-reset flag while core reset is still driven, to show that setting wins over clearing.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    localparam int REG_W  = 8;
    localparam int DOM_N  = 3;
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_STAT = 1'b1;
    localparam int STAT_CORE_WAS = 4;
    localparam int STAT_DBG_WAS  = 6;

    typedef struct packed {
        logic jtag_use;
        logic dbg_rst;
        logic rsv5;
        logic core_rst;
        logic rsv3;
        logic dbg_wake;
        logic mem_wake;
        logic core_wake;
    } ctrl_t;

    typedef struct packed {
        logic             rsv7;
        logic             dbg_was;
        logic             rsv5;
        logic             core_was;
        logic             needed;
        logic [DOM_N-1:0] dom_on;
    } stat_t;

    function automatic ctrl_t ctrl_clean(input ctrl_t c);
        ctrl_t r;
        r      = c;
        r.rsv5 = 1'b0;
        r.rsv3 = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/dpc_ctrl_reg.sv
module dpc_ctrl_reg
    import dpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_ctrl,
    input  ctrl_t wdata,
    output ctrl_t ctrl_q,
    output logic  access_ok
);
    ctrl_t nxt;
    logic  armed_q;

    always_comb begin
        nxt = ctrl_clean(wdata);
        if (ctrl_q.jtag_use) nxt.jtag_use = 1'b0;
        if (nxt.dbg_rst)     nxt.jtag_use = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            armed_q <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_q  <= nxt;
            armed_q <= nxt.jtag_use;
        end
    end

    assign access_ok = armed_q & ctrl_q.jtag_use;

    // R3
    arm_only_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(access_ok) |-> $past(wr_ctrl && wdata.jtag_use && !wdata.dbg_rst && !ctrl_q.jtag_use));
    // R4
    clear_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && access_ok) |=> !access_ok);
    // R5
    rst_blocks_access_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.dbg_rst |-> !access_ok);
endmodule

// File: rtl/dpc_status.sv
module dpc_status
    import dpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_core,
    input  logic             clr_dbg,
    input  logic [DOM_N-1:0] pgood,
    input  logic             needed_in,
    input  logic             core_rst_act,
    input  logic             dbg_rst_act,
    output stat_t            stat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q          <= '0;
            stat_q.core_was <= 1'b1;
            stat_q.dbg_was  <= 1'b1;
        end else begin
            stat_q.dom_on   <= pgood;
            stat_q.needed   <= needed_in;
            stat_q.core_was <= core_rst_act | (stat_q.core_was & ~clr_core);
            stat_q.dbg_was  <= dbg_rst_act  | (stat_q.dbg_was  & ~clr_dbg);
        end
    end

    // R6
    dom_on_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat_q.dom_on == $past(pgood)));
    // R7
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        (core_rst_act || dbg_rst_act) |=> ((stat_q.core_was || !$past(core_rst_act)) && (stat_q.dbg_was || !$past(dbg_rst_act))));
    // R8
    w1c_zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q.core_was && !clr_core) |=> stat_q.core_was);
endmodule

// File: rtl/dbg_pwr_ctl.sv
module dbg_pwr_ctl
    import dpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             core_pgood,
    input  logic             mem_pgood,
    input  logic             dbg_pgood,
    input  logic             core_needed,
    output logic             core_pwr_req,
    output logic             mem_pwr_req,
    output logic             dbg_pwr_req,
    output logic             core_rst_o,
    output logic             dbg_rst_o,
    output logic             jtag_access_ok
);
    ctrl_t ctrl_q;
    stat_t stat_q;
    logic  wr_ctrl, wr_stat;

    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_stat = reg_wr && (reg_sel == SEL_STAT);

    dpc_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wdata     (ctrl_t'(reg_wdata)),
        .ctrl_q    (ctrl_q),
        .access_ok (jtag_access_ok)
    );

    dpc_status u_stat (
        .clk          (clk),
        .rst          (rst),
        .clr_core     (wr_stat && reg_wdata[STAT_CORE_WAS]),
        .clr_dbg      (wr_stat && reg_wdata[STAT_DBG_WAS]),
        .pgood        ({dbg_pgood, mem_pgood, core_pgood}),
        .needed_in    (core_needed),
        .core_rst_act (ctrl_q.core_rst),
        .dbg_rst_act  (ctrl_q.dbg_rst),
        .stat_q       (stat_q)
    );

    assign core_pwr_req = ctrl_q.core_wake;
    assign mem_pwr_req  = ctrl_q.mem_wake;
    assign dbg_pwr_req  = ctrl_q.dbg_wake;
    assign core_rst_o   = ctrl_q.core_rst;
    assign dbg_rst_o    = ctrl_q.dbg_rst;
    assign reg_rdata    = (reg_sel == SEL_STAT) ? REG_W'(stat_q) : REG_W'(ctrl_q);
endmodule

// File: tb/tb_dbg_pwr_ctl.sv
module tb_dbg_pwr_ctl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic core_pgood = 0, mem_pgood = 0, dbg_pgood = 0, core_needed = 0;
    logic core_pwr_req, mem_pwr_req, dbg_pwr_req, core_rst_o, dbg_rst_o, jtag_access_ok;

    always #2.5 clk = ~clk;

    dbg_pwr_ctl dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_pgood(core_pgood), .mem_pgood(mem_pgood), .dbg_pgood(dbg_pgood),
        .core_needed(core_needed), .core_pwr_req(core_pwr_req), .mem_pwr_req(mem_pwr_req),
        .dbg_pwr_req(dbg_pwr_req), .core_rst_o(core_rst_o), .dbg_rst_o(dbg_rst_o),
        .jtag_access_ok(jtag_access_ok)
    );

    typedef struct {
        logic       sel;
        logic [7:0] rd;
        logic [5:0] outs;
        string      tag;
    } item_t;
    item_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // outs = {access, dbg_rst, core_rst, dbg_req, mem_req, core_req}
    always @(negedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            logic [5:0] got;
            it  = q.pop_front();
            got = {jtag_access_ok, dbg_rst_o, core_rst_o, dbg_pwr_req, mem_pwr_req, core_pwr_req};
            n_cmp++;
            if (reg_rdata !== it.rd || got !== it.outs) begin
                n_bad++;
                $display("FAIL %s sel=%0d: rdata=%h outs=%b expected rdata=%h outs=%b",
                         it.tag, it.sel, reg_rdata, got, it.rd, it.outs);
            end
        end
    end

    task automatic expect_rd(input logic sel, input logic [7:0] rd, input logic [5:0] outs, input string tag);
        item_t it;
        @(negedge clk);
        reg_wr = 0; reg_sel = sel;
        it.sel = sel; it.rd = rd; it.outs = outs; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wr = 1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_rd(0, 8'h00, 6'b000000, "R1 ctrl in reset");
        expect_rd(1, 8'h50, 6'b000000, "R1 status in reset");
        rst = 0;
        expect_rd(1, 8'h50, 6'b000000, "R1 status after reset");
        wr(1, 8'h50);
        expect_rd(1, 8'h00, 6'b000000, "R8 w1c both flags");
        @(negedge clk); core_pgood = 1; mem_pgood = 1;
        expect_rd(1, 8'h03, 6'b000000, "R6 core/mem on");
        @(negedge clk); dbg_pgood = 1; core_needed = 1;
        expect_rd(1, 8'h0F, 6'b000000, "R6 dbg on and needed");
        wr(0, 8'h2F);
        expect_rd(0, 8'h07, 6'b000111, "R2 wakeups, reserved bits read 0");
        wr(0, 8'h87);
        expect_rd(0, 8'h87, 6'b100111, "R3 arm on 0-to-1");
        wr(0, 8'h87);
        expect_rd(0, 8'h07, 6'b000111, "R4 rewrite while set clears");
        wr(0, 8'h87);
        expect_rd(0, 8'h87, 6'b100111, "R3 re-arm");
        wr(0, 8'h50);
        expect_rd(0, 8'h50, 6'b011000, "R2 R5 both resets drop access");
        expect_rd(1, 8'h5F, 6'b011000, "R7 sticky set by resets");
        wr(0, 8'hC0);
        expect_rd(0, 8'h40, 6'b010000, "R5 enable refused under debug reset");
        wr(0, 8'h00);
        wr(1, 8'h10);
        expect_rd(1, 8'h4F, 6'b000000, "R8 clear core flag only");
        wr(1, 8'h0F);
        expect_rd(1, 8'h4F, 6'b000000, "R8 zero and other bits ignored");
        wr(1, 8'h40);
        expect_rd(1, 8'h0F, 6'b000000, "R8 clear debug flag");
        wr(0, 8'h10);
        wr(1, 8'h10);
        expect_rd(1, 8'h1F, 6'b001000, "R8 R7 set beats clear");
        wr(0, 8'h00);
        wr(1, 8'h10);
        expect_rd(1, 8'h0F, 6'b000000, "R8 clear after release");
        @(negedge clk); core_pgood = 0; mem_pgood = 0; dbg_pgood = 0; core_needed = 0;
        expect_rd(1, 8'h00, 6'b000000, "R6 domains off");
        wr(0, 8'h87);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        expect_rd(0, 8'h00, 6'b000000, "R1 mid-run reset ctrl");
        expect_rd(1, 8'h50, 6'b000000, "R1 R7 mid-run reset sticky");
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule